// File: doc/BRIEF.md
# SONET Framing Byte-Aligning Deserializer

This block sits on the receive side of a SONET/SDH line interface. It takes a serial NRZ stream, one bit per rising edge of the high-speed clock, and packs it most-significant-bit first into bytes. It drives an 8-bit parallel word together with a one-cycle byte strobe that fires once every eight high-speed clocks; the strobe acts as a divide-by-8 byte clock enable.

Searching is controlled by a level-sensitive out-of-frame input. While searching is allowed, a 48-bit window is compared at every bit position against three A1 bytes (0xF6) followed by three A2 bytes (0x28). When the pattern is found, the byte boundary moves so that the third A2 byte becomes the current parallel word, and a frame pulse covers that byte. When searching is off and no detection is pending, the current byte phase is kept. A loss-of-signal input forces the parallel word to zero without disturbing the byte phase.

Top module: `sonet_byte_aligner`

## Requirements
- R1: Serial bits are packed MSB first; after reset release the byte strobe is high for one clock in every eight, and each word holds the eight bits sampled on the eight clocks before its strobe edge (first bit in bit 7).
- R2: A detection happens only on three consecutive A1 bytes (8'hF6) followed at once by three consecutive A2 bytes (8'h28), at any of the eight bit offsets.
- R3: One clock after the last bit of the third A2 byte is sampled, the parallel word is 8'h28 with the strobe high; the next word, eight clocks later, holds the eight bits that followed the pattern.
- R4: The frame pulse rises together with the strobe of the third A2 word and stays high for exactly eight clocks (one byte period).
- R5: With out-of-frame held low and no detection pending, no frame pulse is produced and the byte phase set at reset is kept.
- R6: With out-of-frame held high, searching continues after a frame is found; a second pattern at a new bit offset realigns the bytes and produces a second pulse.
- R7: If out-of-frame falls after the A1-to-A2 boundary has been sampled while it was high, that frame is still found and pulsed; if it falls before the boundary, no pulse is produced.
- R8: Raising out-of-frame 32 clocks (four byte periods) before the A1-to-A2 boundary is enough for the frame to be found.
- R9: While loss-of-signal is high the parallel word reads 8'h00; the strobe, frame pulse and byte phase are not affected.
- R10: Reset (synchronous, active high) clears the parallel word, strobe and frame pulse to zero and restarts the byte phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-speed bit clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial NRZ data, sampled on the rising edge |
| oof_in | input | 1 | Out-of-frame level; high allows searching |
| los_in | input | 1 | Loss of signal; forces the parallel word to zero |
| rx_byte | output | 8 | Parallel receive word |
| byte_stb | output | 1 | One-clock strobe marking a new word (byte clock enable) |
| frame_pulse | output | 1 | High for the byte period of the aligned third A2 word |

## Verification
The bench places the framing pattern at several bit offsets, including offsets 0 and 7, so a matcher that only looks on the current byte grid misses the odd offsets and an off-by-one shift returns a rotated A2 instead of 8'h28. It drops out-of-frame either inside the A2 bytes or inside the A1 bytes: a design without a pending-detection hold loses the first kind of frame, and one that latches too early pulses on the second. With out-of-frame low it checks every word against the reset byte grid, which exposes a design that realigns silently, and it sends two frames at different offsets to catch a searcher that stops after the first hit. Loss-of-signal is applied while the A2 word is held, so a design that gated the strobe or cleared the byte register instead of the output would show it.

// File: rtl/sba_pkg.sv
package sba_pkg;

    localparam int BYTE_W = 8;
    localparam int PHASE_W = $clog2(BYTE_W);

    typedef logic [BYTE_W-1:0] byte_t;

    // Registered output record of the byte stage
    typedef struct packed {
        byte_t data;
        logic  strobe;
        logic  frame;
    } rx_word_t;

    localparam rx_word_t RX_WORD_IDLE = '{data: '0, strobe: 1'b0, frame: 1'b0};

    // Default framing byte values
    localparam byte_t FRAME_A1 = 8'hF6;
    localparam byte_t FRAME_A2 = 8'h28;

    function automatic logic phase_wrap(input logic [PHASE_W-1:0] ph);
        return ph == PHASE_W'(BYTE_W - 1);
    endfunction

endpackage

// File: rtl/sba_bit_window.sv
module sba_bit_window #(
    parameter int WIN_W = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_in,
    output logic [WIN_W-1:0] win
);
    // Newest bit enters at bit 0; oldest sits at WIN_W-1
    always_ff @(posedge clk) begin
        if (rst) begin
            win <= '0;
        end else begin
            win <= {win[WIN_W-2:0], bit_in};
        end
    end
endmodule

// File: rtl/sba_frame_match.sv
module sba_frame_match
    import sba_pkg::*;
#(
    parameter int    REP = 3,
    parameter byte_t A1  = FRAME_A1,
    parameter byte_t A2  = FRAME_A2
) (
    input  logic [2*REP*BYTE_W-1:0] win,
    output logic                    prefix_hit,
    output logic                    full_hit
);
    localparam int WIN_W  = 2 * REP * BYTE_W;
    localparam int HALF_W = REP * BYTE_W;

    logic [WIN_W-1:0]  pattern;
    logic [HALF_W-1:0] a1_run;

    for (genvar g = 0; g < REP; g++) begin : g_fields
        assign pattern[WIN_W-1-g*BYTE_W -: BYTE_W]  = A1;
        assign pattern[HALF_W-1-g*BYTE_W -: BYTE_W] = A2;
        assign a1_run[HALF_W-1-g*BYTE_W -: BYTE_W]  = A1;
    end

    // Full pattern: all A1 then all A2, oldest bits first
    assign full_hit   = (win == pattern);
    // The newest REP bytes are the A1 run: A1-to-A2 boundary just reached
    assign prefix_hit = (win[HALF_W-1:0] == a1_run);
endmodule

// File: rtl/sba_search_ctl.sv
module sba_search_ctl #(
    parameter int PEND_LEN = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic oof_in,
    input  logic prefix_hit,
    input  logic full_hit,
    output logic realign
);
    localparam int CNT_W = $clog2(PEND_LEN + 1);

    logic             oof_q;
    logic [CNT_W-1:0] pend_cnt;
    logic             pending;

    assign pending = (pend_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            oof_q    <= 1'b0;
            pend_cnt <= '0;
        end else begin
            oof_q <= oof_in;
            if (oof_q && prefix_hit) begin
                pend_cnt <= CNT_W'(PEND_LEN);
            end else if (pending) begin
                pend_cnt <= pend_cnt - 1'b1;
            end
        end
    end

    // Accept a match while searching, or one whose A1 run was seen while searching
    assign realign = full_hit && (oof_q || pending);
endmodule

// File: rtl/sba_byte_phase.sv
module sba_byte_phase
    import sba_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     realign,
    input  byte_t    last_byte,
    output rx_word_t word
);
    logic [PHASE_W-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            word  <= RX_WORD_IDLE;
        end else if (realign) begin
            // Third A2 byte is complete now: restart the byte grid here
            phase       <= PHASE_W'(1);
            word.data   <= last_byte;
            word.strobe <= 1'b1;
            word.frame  <= 1'b1;
        end else begin
            phase       <= phase + 1'b1;
            word.strobe <= (phase == '0);
            if (phase == '0) begin
                word.data  <= last_byte;
                word.frame <= 1'b0;
            end
            if (phase_wrap(phase)) begin
                phase <= '0;
            end
        end
    end
endmodule

// File: rtl/sonet_byte_aligner.sv
module sonet_byte_aligner
    import sba_pkg::*;
#(
    parameter int    REP = 3,
    parameter byte_t A1  = FRAME_A1,
    parameter byte_t A2  = FRAME_A2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ser_in,
    input  logic        oof_in,
    input  logic        los_in,
    output logic [7:0]  rx_byte,
    output logic        byte_stb,
    output logic        frame_pulse
);
    localparam int WIN_W    = 2 * REP * BYTE_W;
    localparam int PEND_LEN = REP * BYTE_W;

    logic [WIN_W-1:0] win;
    logic             prefix_hit;
    logic             full_hit;
    logic             realign;
    rx_word_t         word;

    sba_bit_window #(.WIN_W(WIN_W)) u_window (
        .clk    (clk),
        .rst    (rst),
        .bit_in (ser_in),
        .win    (win)
    );

    sba_frame_match #(.REP(REP), .A1(A1), .A2(A2)) u_match (
        .win        (win),
        .prefix_hit (prefix_hit),
        .full_hit   (full_hit)
    );

    sba_search_ctl #(.PEND_LEN(PEND_LEN)) u_search (
        .clk        (clk),
        .rst        (rst),
        .oof_in     (oof_in),
        .prefix_hit (prefix_hit),
        .full_hit   (full_hit),
        .realign    (realign)
    );

    sba_byte_phase u_phase (
        .clk       (clk),
        .rst       (rst),
        .realign   (realign),
        .last_byte (win[BYTE_W-1:0]),
        .word      (word)
    );

    assign rx_byte     = los_in ? '0 : word.data;
    assign byte_stb    = word.strobe;
    assign frame_pulse = word.frame;
endmodule

// File: rtl/sba_checker.sv
module sba_checker #(
    parameter int       BYTE_W = 8,
    parameter int       REP    = 3,
    parameter logic [7:0] A2   = 8'h28
) (
    input logic       clk,
    input logic       rst,
    input logic       oof_in,
    input logic       los_in,
    input logic [7:0] rx_byte,
    input logic       byte_stb,
    input logic       frame_pulse
);
    localparam int OOF_LIMIT = 2 * REP * BYTE_W + 2;

    logic [4:0] gap;
    logic       seen;
    logic [6:0] since_oof;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap       <= '0;
            seen      <= 1'b0;
            since_oof <= 7'h7F;
        end else begin
            if (byte_stb) begin
                gap  <= '0;
                seen <= 1'b1;
            end else if (gap != 5'h1F) begin
                gap <= gap + 1'b1;
            end
            if (oof_in) since_oof <= '0;
            else if (since_oof != 7'h7F) since_oof <= since_oof + 1'b1;
        end
    end

    AST_STB_SPACING: assert property (@(posedge clk) disable iff (rst)
        (byte_stb && seen && !$rose(frame_pulse)) |-> (gap == 5'(BYTE_W - 1))); // R1

    AST_FP_ON_STB: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_pulse) |-> byte_stb); // R4

    AST_FP_END_ON_STB: assert property (@(posedge clk) disable iff (rst)
        $fell(frame_pulse) |-> byte_stb); // R4

    AST_FP_DATA_A2: assert property (@(posedge clk) disable iff (rst)
        ($rose(frame_pulse) && !los_in) |-> (rx_byte == A2)); // R3

    AST_FP_NEEDS_OOF: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_pulse) |-> (since_oof <= 7'(OOF_LIMIT))); // R5

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!byte_stb && !frame_pulse)); // R10
endmodule

bind sonet_byte_aligner sba_checker #(
    .BYTE_W (sba_pkg::BYTE_W),
    .REP    (REP),
    .A2     (A2)
) u_sba_checker (
    .clk         (clk),
    .rst         (rst),
    .oof_in      (oof_in),
    .los_in      (los_in),
    .rx_byte     (rx_byte),
    .byte_stb    (byte_stb),
    .frame_pulse (frame_pulse)
);

// File: tb/tb_sonet_byte_aligner.sv
module tb_sonet_byte_aligner;

    localparam int CLK_PERIOD = 10;
    localparam int MAXB = 160;
    localparam logic [7:0] A1 = 8'hF6;
    localparam logic [7:0] A2 = 8'h28;

    // Vector fields: {junk bits[5:0], oof mode[2:0], payload[7:0], expect pulse}
    // oof modes: 0 low, 1 high, 2 drop inside A2, 3 drop inside A1, 4 raise 32 bits before boundary
    localparam int NCASE = 8;
    localparam logic [17:0] CASES [NCASE] = '{
        {6'd0,  3'd1, 8'hA5, 1'b1},
        {6'd3,  3'd1, 8'h3C, 1'b1},
        {6'd7,  3'd1, 8'h81, 1'b1},
        {6'd13, 3'd0, 8'h5A, 1'b0},
        {6'd10, 3'd2, 8'hC3, 1'b1},
        {6'd12, 3'd3, 8'h99, 1'b0},
        {6'd17, 3'd4, 8'h66, 1'b1},
        {6'd22, 3'd1, 8'h0F, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_in = 1'b0;
    logic       oof_in = 1'b0;
    logic       los_in = 1'b0;
    logic [7:0] rx_byte;
    logic       byte_stb;
    logic       frame_pulse;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic       st_bit [MAXB];
    logic       st_oof [MAXB];
    logic       st_los [MAXB];
    logic [7:0] ob_data [MAXB];
    logic       ob_stb [MAXB];
    logic       ob_fp [MAXB];
    int         st_len;

    always #(CLK_PERIOD/2) clk = ~clk;

    sonet_byte_aligner dut (
        .clk         (clk),
        .rst         (rst),
        .ser_in      (ser_in),
        .oof_in      (oof_in),
        .los_in      (los_in),
        .rx_byte     (rx_byte),
        .byte_stb    (byte_stb),
        .frame_pulse (frame_pulse)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_stream();
        for (int i = 0; i < MAXB; i++) begin
            st_bit[i] = 1'b0; st_oof[i] = 1'b0; st_los[i] = 1'b0;
        end
        st_len = 0;
    endtask

    task automatic put_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            st_bit[st_len] = b[i];
            st_len++;
        end
    endtask

    task automatic put_frame();
        for (int i = 0; i < 3; i++) put_byte(A1);
        for (int i = 0; i < 3; i++) put_byte(A2);
    endtask

    function automatic logic [7:0] byte_at(input int start);
        logic [7:0] b;
        for (int i = 0; i < 8; i++) b[7-i] = st_bit[start+i];
        return b;
    endfunction

    // Hold reset for a few clocks, ending just after a falling edge
    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // ob_*[k] is observed while bit k is driven: state after the edge that sampled bit k-1
    task automatic run_stream();
        for (int k = 0; k < st_len; k++) begin
            if (k != 0) @(negedge clk);
            rst    = 1'b0;
            ser_in = st_bit[k];
            oof_in = st_oof[k];
            los_in = st_los[k];
            #1;
            ob_data[k] = rx_byte;
            ob_stb[k]  = byte_stb;
            ob_fp[k]   = frame_pulse;
        end
    endtask

    function automatic int fp_count();
        int n = 0;
        for (int k = 0; k < st_len; k++) if (ob_fp[k]) n++;
        return n;
    endfunction

    task automatic run_case(input int idx);
        int junk, mode, lastbit, bnd;
        logic [7:0] pay;
        bit expect_fp, grid_ok;
        junk      = int'(CASES[idx][17:12]);
        mode      = int'(CASES[idx][11:9]);
        pay       = CASES[idx][8:1];
        expect_fp = CASES[idx][0];
        clear_stream();
        st_len = junk;
        put_frame();
        put_byte(pay);
        put_byte(8'h00);
        put_byte(8'h00);
        lastbit = junk + 47;
        bnd     = junk + 23;
        for (int k = 0; k < st_len; k++) begin
            case (mode)
                1: st_oof[k] = 1'b1;
                2: st_oof[k] = (k < junk + 32);
                3: st_oof[k] = (k < junk + 16);
                4: st_oof[k] = (k >= bnd + 1 - 32);
                default: st_oof[k] = 1'b0;
            endcase
        end
        do_reset();
        run_stream();
        // R10: outputs cleared while in reset
        chk(ob_data[0] == 8'h00 && !ob_stb[0] && !ob_fp[0], "R10 reset state",
            {ob_data[0], 7'b0, ob_stb[0], 7'b0, ob_fp[0]}, 0);
        if (expect_fp) begin
            chk(ob_fp[lastbit+2] && ob_stb[lastbit+2] && ob_data[lastbit+2] == A2,
                (mode == 2) ? "R7 frame kept after late oof drop" :
                (mode == 4) ? "R8 oof raised four bytes early" : "R2 R3 aligned third A2",
                {ob_fp[lastbit+2], ob_stb[lastbit+2], ob_data[lastbit+2]}, {2'b11, A2});
            chk(fp_count() == 8, "R4 pulse width", fp_count(), 8);
            chk(ob_stb[lastbit+10] && !ob_fp[lastbit+10] && ob_data[lastbit+10] == pay,
                "R3 byte after pattern", ob_data[lastbit+10], pay);
        end else begin
            chk(fp_count() == 0, (mode == 3) ? "R7 no pulse after early oof drop" : "R5 no pulse",
                fp_count(), 0);
            grid_ok = 1'b1;
            for (int m = 1; 8*m + 1 < st_len; m++) begin
                if (!ob_stb[8*m+1] || ob_data[8*m+1] != byte_at(8*m-8)) grid_ok = 1'b0;
            end
            chk(grid_ok, "R5 R1 byte phase kept", grid_ok, 1);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=expired expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int lastbit, l2;
        bit stb_ok;
        // Table walk
        for (int i = 0; i < NCASE; i++) run_case(i);

        // R1: byte grid after reset with a plain byte stream
        clear_stream();
        put_byte(8'h13); put_byte(8'hC7); put_byte(8'h80); put_byte(8'h01); put_byte(8'h00);
        do_reset();
        run_stream();
        stb_ok = 1'b1;
        for (int k = 1; k < st_len; k++) begin
            if (ob_stb[k] != ((k - 1) % 8 == 0)) stb_ok = 1'b0;
        end
        chk(stb_ok, "R1 strobe one in eight", stb_ok, 1);
        chk(ob_data[9] == 8'h13 && ob_data[17] == 8'hC7 && ob_data[25] == 8'h80,
            "R1 MSB first packing", ob_data[17], 8'hC7);

        // R6: two frames at different offsets with oof held high
        clear_stream();
        st_len = 5;
        put_frame(); put_byte(8'h4B);
        st_len = st_len + 3;
        put_frame(); put_byte(8'hB4);
        put_byte(8'h00); put_byte(8'h00);
        for (int k = 0; k < st_len; k++) st_oof[k] = 1'b1;
        lastbit = 5 + 47;
        l2 = 64 + 47;
        do_reset();
        run_stream();
        chk(fp_count() == 16, "R6 two pulses", fp_count(), 16);
        chk(ob_data[lastbit+10] == 8'h4B, "R6 first payload", ob_data[lastbit+10], 8'h4B);
        chk(ob_fp[l2+2] && ob_data[l2+2] == A2 && ob_data[l2+10] == 8'hB4,
            "R6 second realign", ob_data[l2+10], 8'hB4);

        // R9: loss of signal zeroes the word but not strobe, pulse or phase
        clear_stream();
        put_frame(); put_byte(8'hE1); put_byte(8'h00);
        for (int k = 0; k < st_len; k++) st_oof[k] = 1'b1;
        lastbit = 47;
        st_los[lastbit+2] = 1'b1;
        st_los[lastbit+4] = 1'b1;
        do_reset();
        run_stream();
        chk(ob_data[lastbit+2] == 8'h00 && ob_stb[lastbit+2] && ob_fp[lastbit+2],
            "R9 zero word strobe kept", {ob_data[lastbit+2], 7'b0, ob_stb[lastbit+2]}, 1);
        chk(ob_data[lastbit+4] == 8'h00 && ob_data[lastbit+5] == A2, "R9 word restored",
            ob_data[lastbit+5], A2);
        chk(ob_data[lastbit+10] == 8'hE1 && fp_count() == 8, "R9 phase unaffected",
            ob_data[lastbit+10], 8'hE1);

        // R10: reset during a held frame word clears outputs
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        #1;
        chk(rx_byte == 8'h00 && !byte_stb && !frame_pulse, "R10 mid-run reset",
            {rx_byte, 7'b0, byte_stb}, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule